// File: doc/BRIEF.md
# I2C Bus Phase Timer

This block shapes the clock and data lines of an I2C master. A byte engine above it asks for one bus event at a time: a START (or a repeated START), one data bit, or a STOP. The block then walks the lines through the phases of that event. Each phase lasts for a count taken from packed timing words. Every count is measured in ticks of a shared clock divider. The block reports the end of each event with a one-cycle pulse.

The line outputs are in open-drain sense: 1 means released (the bus is pulled high), and 0 means driven low. After a START or a bit, SCL is left held low until the next request. After a STOP, both lines are released. One bit request covers both directions. To read a bit, the engine requests bit value 1, which releases SDA. The block then samples the SDA input at the last cycle of the high phase.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset, sclOut = 1, sdaOut = 1 and ready = 1, and no done pulse is asserted.
- R2: A phase whose count field holds n lasts (n+1)·(div+1) input clocks. A count of 0 gives one tick. div is bits 23:16 of cfgClock.
- R3: A START on a free bus works in three steps. First, both lines stay high for the START setup count (cfgStart bits 31:24). Next, SDA is driven low with SCL high for the START hold count (cfgStart bits 23:16). Finally, SCL goes low and startDone pulses in the first cycle of that state.
- R4: A START while SCL is held low first releases SDA with SCL still low for the release count (cfgClock bits 7:0). It then follows the R3 sequence.
- R5: A bit request first keeps SDA at its old value with SCL low for the data-hold count (cfgHold bits 7:0). It then drives the new value with SCL low for max(setup+1, low−hold) ticks. Here setup is cfgData bits 31:24 and low is cfgData bits 15:8. SCL therefore never rises sooner than the setup count after the SDA change.
- R6: The SCL high part of a bit has two parts in order: (high+1) ticks (high is cfgData bits 7:0), then 8 + 2·filterCycles input clocks. After that, SCL falls and bitDone pulses. When low ≥ hold+setup+1, the total low-plus-high time equals (div+1)·(low+high+2) + 8 + 2·filterCycles.
- R7: rxBit takes the value of sdaIn in the last high cycle of a bit and presents it together with bitDone.
- R8: A STOP from a held bus first drives SDA low with SCL low for the data-hold count. It then releases SCL for the STOP setup count (cfgStart bits 15:8). Finally it releases SDA, and stopDone pulses in that first released cycle.
- R9: A STOP on a free bus pulses stopDone in the cycle after it is accepted and leaves both lines released.
- R10: A bit request on a free bus is ignored: lines, ready and pulses do not change.
- R11: Requests asserted together in a ready cycle are served in the order START first, then STOP, then bit.
- R12: Requests asserted while ready = 0 are ignored.
- R13: ready is 1 only on a free or held bus. At most one done pulse is high at a time, and a pulse appears only with ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgStart | input | 32 | START setup [31:24], START hold [23:16], STOP setup [15:8] |
| cfgData | input | 32 | Data setup [31:24], SCL low [15:8], SCL high [7:0] |
| cfgClock | input | 32 | Divider [23:16], repeated-start release [7:0] |
| cfgHold | input | 32 | Data hold [7:0] |
| filterCycles | input | 3 | Input filter depth, adds 2 clocks each to the high phase |
| reqStart | input | 1 | Request START / repeated START |
| reqBit | input | 1 | Request one data bit |
| reqStop | input | 1 | Request STOP |
| bitValue | input | 1 | Value driven for a bit request (1 releases SDA) |
| sdaIn | input | 1 | Sampled bus data line |
| sclOut | output | 1 | Clock line, 1 = released |
| sdaOut | output | 1 | Data line, 1 = released |
| ready | output | 1 | A new request can be accepted |
| startDone | output | 1 | One-cycle pulse at the end of a START |
| bitDone | output | 1 | One-cycle pulse at the end of a bit |
| stopDone | output | 1 | One-cycle pulse at the end of a STOP |
| rxBit | output | 1 | Bus value sampled during the last bit |

## Verification
The main function is exercised with three timing sets:
- The first has a divider of 1 and a long SCL low count. Its fall-to-fall timing must match the period formula, which separates the hold and setup split inside the low phase from the fixed high-phase overhead.
- The second has a divider of 0 and zero counts. With the largest filter depth and a low count shorter than hold plus setup, it shows whether each count still yields one tick and whether the low phase stretches.
- The third has a divider of 3. It catches a tick length computed from the count alone, without the divider.

Each set runs START, bits of both values with differing sampled inputs, a repeated START, and a STOP. Separate sequences cover requests on a free bus, requests while busy, and simultaneous requests, to separate ignoring from serving and to fix the priority.

// File: rtl/i2c_bus_timer_pkg.sv
package i2c_bus_timer_pkg;
  localparam int CNT_W  = 8;
  localparam int PH_W   = CNT_W + 1;
  localparam int FILT_W = 3;
  localparam int OVH_BASE = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HELD, ST_REL, ST_SSU, ST_SHD,
    ST_BLH, ST_BLS, ST_BHI, ST_BOV, ST_PLO, ST_PSU
  } bus_state_t;

  typedef struct packed {
    logic            load;
    logic            clkMode;
    logic [PH_W-1:0] count;
  } phase_ctl_t;
endpackage

// File: rtl/i2c_bus_timer_counter.sv
module i2c_bus_timer_counter
  import i2c_bus_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] divide,
  input  phase_ctl_t       ctl,
  output logic             phaseEnd
);
  logic [CNT_W-1:0] preCnt;
  logic [PH_W-1:0]  tickCnt;
  logic             clkModeQ;
  logic             tickEdge;

  assign tickEdge = clkModeQ || (preCnt == '0);
  assign phaseEnd = tickEdge && (tickCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      tickCnt  <= '0;
      clkModeQ <= 1'b1;
    end else if (ctl.load) begin
      preCnt   <= divide;
      tickCnt  <= ctl.count;
      clkModeQ <= ctl.clkMode;
    end else if (!phaseEnd) begin
      if (tickEdge) begin
        tickCnt <= tickCnt - 1'b1;
        preCnt  <= divide;
      end else begin
        preCnt  <= preCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_timer_ctrl.sv
module i2c_bus_timer_ctrl
  import i2c_bus_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  startSetup,
  input  logic [CNT_W-1:0]  startHold,
  input  logic [CNT_W-1:0]  stopSetup,
  input  logic [CNT_W-1:0]  dataSetup,
  input  logic [CNT_W-1:0]  dataHold,
  input  logic [CNT_W-1:0]  sclLow,
  input  logic [CNT_W-1:0]  sclHigh,
  input  logic [CNT_W-1:0]  relCount,
  input  logic [FILT_W-1:0] filterCycles,
  input  logic              reqStart,
  input  logic              reqBit,
  input  logic              reqStop,
  input  logic              bitValue,
  input  logic              sdaIn,
  input  logic              phaseEnd,
  output phase_ctl_t        ctl,
  output logic              sclOut,
  output logic              sdaOut,
  output logic              ready,
  output logic              startDone,
  output logic              bitDone,
  output logic              stopDone,
  output logic              rxBit
);
  bus_state_t state, stateN;
  logic sdaReg, sdaN, bitReg, bitN, rxN;
  logic startP, bitP, stopP;
  logic [PH_W:0]   lowDiff;
  logic [PH_W-1:0] lowRest;
  logic [PH_W-1:0] ovhCnt;

  // Remaining low time after the hold part, never shorter than setup.
  assign lowDiff = {2'b00, sclLow} - {2'b00, dataHold} - {{PH_W{1'b0}}, 1'b1};
  always_comb begin
    if (lowDiff[PH_W] || (lowDiff[PH_W-1:0] < {1'b0, dataSetup}))
      lowRest = {1'b0, dataSetup};
    else
      lowRest = lowDiff[PH_W-1:0];
  end
  assign ovhCnt = PH_W'(OVH_BASE) + PH_W'({filterCycles, 1'b0});

  function automatic phase_ctl_t ticks(input logic [PH_W-1:0] n);
    ticks = '{load: 1'b1, clkMode: 1'b0, count: n};
  endfunction

  always_comb begin
    stateN = state;
    ctl    = '0;
    sdaN   = sdaReg;
    bitN   = bitReg;
    rxN    = rxBit;
    startP = 1'b0;
    bitP   = 1'b0;
    stopP  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqStart) begin
          stateN = ST_SSU; ctl = ticks({1'b0, startSetup});
        end else if (reqStop) begin
          stopP = 1'b1;
        end
      end
      ST_HELD: begin
        if (reqStart) begin
          stateN = ST_REL; ctl = ticks({1'b0, relCount});
        end else if (reqStop) begin
          stateN = ST_PLO; ctl = ticks({1'b0, dataHold});
        end else if (reqBit) begin
          stateN = ST_BLH; ctl = ticks({1'b0, dataHold}); bitN = bitValue;
        end
      end
      ST_REL: if (phaseEnd) begin stateN = ST_SSU; ctl = ticks({1'b0, startSetup}); end
      ST_SSU: if (phaseEnd) begin stateN = ST_SHD; ctl = ticks({1'b0, startHold}); end
      ST_SHD: if (phaseEnd) begin stateN = ST_HELD; sdaN = 1'b0; startP = 1'b1; end
      ST_BLH: if (phaseEnd) begin stateN = ST_BLS; ctl = ticks(lowRest); end
      ST_BLS: if (phaseEnd) begin stateN = ST_BHI; ctl = ticks({1'b0, sclHigh}); end
      ST_BHI: if (phaseEnd) begin
        stateN = ST_BOV;
        ctl = '{load: 1'b1, clkMode: 1'b1, count: ovhCnt};
      end
      ST_BOV: if (phaseEnd) begin
        stateN = ST_HELD; sdaN = bitReg; bitP = 1'b1; rxN = sdaIn;
      end
      ST_PLO: if (phaseEnd) begin stateN = ST_PSU; ctl = ticks({1'b0, stopSetup}); end
      ST_PSU: if (phaseEnd) begin stateN = ST_IDLE; sdaN = 1'b1; stopP = 1'b1; end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sdaReg    <= 1'b1;
      bitReg    <= 1'b1;
      rxBit     <= 1'b1;
      startDone <= 1'b0;
      bitDone   <= 1'b0;
      stopDone  <= 1'b0;
    end else begin
      state     <= stateN;
      sdaReg    <= sdaN;
      bitReg    <= bitN;
      rxBit     <= rxN;
      startDone <= startP;
      bitDone   <= bitP;
      stopDone  <= stopP;
    end
  end

  always_comb begin
    sclOut = 1'b0;
    sdaOut = sdaReg;
    case (state)
      ST_IDLE:        begin sclOut = 1'b1; sdaOut = 1'b1; end
      ST_REL:         begin sclOut = 1'b0; sdaOut = 1'b1; end
      ST_SSU:         begin sclOut = 1'b1; sdaOut = 1'b1; end
      ST_SHD:         begin sclOut = 1'b1; sdaOut = 1'b0; end
      ST_BLS:         begin sclOut = 1'b0; sdaOut = bitReg; end
      ST_BHI, ST_BOV: begin sclOut = 1'b1; sdaOut = bitReg; end
      ST_PLO:         begin sclOut = 1'b0; sdaOut = 1'b0; end
      ST_PSU:         begin sclOut = 1'b1; sdaOut = 1'b0; end
      default:        begin sclOut = 1'b0; sdaOut = sdaReg; end
    endcase
  end

  assign ready = (state == ST_IDLE) || (state == ST_HELD);

  // SDA may fall under a high SCL only as the START hold begins (R3).
  assert_sda_fall_is_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && $fell(sdaOut)) |-> (state == ST_SHD));
  assert_start_ends_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    startDone |-> (!sclOut && !sdaOut));
  // SDA may rise under a high SCL only as a STOP completes (R8).
  assert_sda_rise_is_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && $rose(sdaOut)) |-> stopDone);
  assert_bit_ends_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitDone |-> !sclOut);
  assert_pulse_onehot_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startDone, bitDone, stopDone}));
  assert_pulse_with_ready_R13: assert property (@(posedge clk) disable iff (!rstN)
    (startDone || bitDone || stopDone) |-> ready);
endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer
  import i2c_bus_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgStart,
  input  logic [31:0]       cfgData,
  input  logic [31:0]       cfgClock,
  input  logic [31:0]       cfgHold,
  input  logic [FILT_W-1:0] filterCycles,
  input  logic              reqStart,
  input  logic              reqBit,
  input  logic              reqStop,
  input  logic              bitValue,
  input  logic              sdaIn,
  output logic              sclOut,
  output logic              sdaOut,
  output logic              ready,
  output logic              startDone,
  output logic              bitDone,
  output logic              stopDone,
  output logic              rxBit
);
  phase_ctl_t ctl;
  logic       phaseEnd;
  logic       unusedCfg;

  assign unusedCfg = ^{cfgStart[7:0], cfgData[23:16], cfgClock[31:24],
                       cfgClock[15:8], cfgHold[31:8]};

  i2c_bus_timer_counter uCounter (
    .clk      (clk),
    .rstN     (rstN),
    .divide   (cfgClock[23:16]),
    .ctl      (ctl),
    .phaseEnd (phaseEnd)
  );

  i2c_bus_timer_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .startSetup   (cfgStart[31:24]),
    .startHold    (cfgStart[23:16]),
    .stopSetup    (cfgStart[15:8]),
    .dataSetup    (cfgData[31:24]),
    .dataHold     (cfgHold[7:0]),
    .sclLow       (cfgData[15:8]),
    .sclHigh      (cfgData[7:0]),
    .relCount     (cfgClock[7:0]),
    .filterCycles (filterCycles),
    .reqStart     (reqStart),
    .reqBit       (reqBit),
    .reqStop      (reqStop),
    .bitValue     (bitValue),
    .sdaIn        (sdaIn),
    .phaseEnd     (phaseEnd),
    .ctl          (ctl),
    .sclOut       (sclOut),
    .sdaOut       (sdaOut),
    .ready        (ready),
    .startDone    (startDone),
    .bitDone      (bitDone),
    .stopDone     (stopDone),
    .rxBit        (rxBit)
  );
endmodule

// File: tb/i2c_bus_timer_test.sv
module i2c_bus_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgStart, cfgData, cfgClock, cfgHold;
  logic [2:0]  filterCycles;
  logic reqStart = 0, reqBit = 0, reqStop = 0, bitValue = 1, sdaIn = 1;
  logic sclOut, sdaOut, ready, startDone, bitDone, stopDone, rxBit;

  always #4 clk = ~clk;

  i2c_bus_timer uut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgData(cfgData),
    .cfgClock(cfgClock), .cfgHold(cfgHold), .filterCycles(filterCycles),
    .reqStart(reqStart), .reqBit(reqBit), .reqStop(reqStop),
    .bitValue(bitValue), .sdaIn(sdaIn), .sclOut(sclOut), .sdaOut(sdaOut),
    .ready(ready), .startDone(startDone), .bitDone(bitDone),
    .stopDone(stopDone), .rxBit(rxBit));

  int tests = 0, fails = 0, cyc = 0;
  int dv, lo, hi, su, hd, ssu, shd, psu, rel, flt;
  logic curScl = 1, curSda = 1;
  int tRise = 0, tFall = 0, tStart = 0;
  logic prevScl = 1;
  string curTag = "R1";
  // entry: scl sda rdy startP bitP stopP rxValid rx
  logic [7:0] expQ[$];

  function automatic int tk(int n);
    return (n + 1) * (dv + 1);
  endfunction

  task automatic pushN(int n, logic s, logic d);
    for (int i = 0; i < n; i++) expQ.push_back({s, d, 6'b0});
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic applyCfg(int d, int l, int h, int s, int ho, int a, int b, int c, int r, int f);
    dv = d; lo = l; hi = h; su = s; hd = ho; ssu = a; shd = b; psu = c; rel = r; flt = f;
    cfgStart = {8'(a), 8'(b), 8'(c), 8'h00};
    cfgData  = {8'(s), 8'h00, 8'(l), 8'(h)};
    cfgClock = {8'h00, 8'(d), 8'h00, 8'(r)};
    cfgHold  = {24'h0, 8'(ho)};
    filterCycles = 3'(f);
  endtask

  task automatic drainQ();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  // R3 / R4 / R11: START, optionally with every request raised together.
  task automatic doStart(bit allReqs);
    @(negedge clk);
    curTag = allReqs ? "R11" : (curScl ? "R3" : "R4");
    reqStart = 1; reqStop = allReqs; reqBit = allReqs;
    if (!curScl) pushN(tk(rel), 0, 1);
    pushN(tk(ssu), 1, 1);
    pushN(tk(shd), 1, 0);
    expQ.push_back(8'b00_1_100_00);
    curScl = 0; curSda = 0;
    @(negedge clk);
    reqStart = 0; reqStop = 0; reqBit = 0;
    drainQ();
  endtask

  // R5 / R6 / R7 / R12: one bit, optionally with a STOP poked while busy.
  task automatic doBit(logic bv, logic rin, bit pokeBusy);
    int lowRestT;
    @(negedge clk);
    curTag = pokeBusy ? "R12" : "R5";
    reqBit = 1; bitValue = bv; sdaIn = rin;
    tStart = cyc + 1;
    lowRestT = (su + 1 > lo - hd) ? su + 1 : lo - hd;
    pushN(tk(hd), 0, curSda);
    pushN(lowRestT * (dv + 1), 0, bv);
    pushN(tk(hi), 1, bv);
    pushN(8 + 2 * flt, 1, bv);
    expQ.push_back({2'b0, bv, 1'b1, 3'b010, 1'b1, rin} >> 0 | {1'b0, bv, 6'b0});
    expQ[expQ.size()-1] = {1'b0, bv, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, rin};
    curSda = bv;
    @(negedge clk);
    reqBit = 0;
    if (pokeBusy) begin
      repeat (2) @(negedge clk);
      reqStop = 1; reqStart = 1;
      @(negedge clk);
      reqStop = 0; reqStart = 0;
    end
    drainQ();
    if (lo >= hd + su + 1)
      check("R6 period", (tRise - tStart) + (tFall - tRise),
            (dv + 1) * (lo + hi + 2) + 8 + 2 * flt);
    check("R7 rxBit", rxBit, rin);
  endtask

  // R8 / R9: STOP.
  task automatic doStop();
    @(negedge clk);
    curTag = curScl ? "R9" : "R8";
    reqStop = 1;
    if (!curScl) begin
      pushN(tk(hd), 0, 0);
      pushN(tk(psu), 1, 0);
    end
    expQ.push_back(8'b11_1_001_00);
    curScl = 1; curSda = 1;
    @(negedge clk);
    reqStop = 0;
    drainQ();
  endtask

  // Reference comparison on every clock, sampled after the edge.
  always @(posedge clk) begin
    logic [7:0] e;
    #2;
    if (rstN) begin
      cyc++;
      if (prevScl == 0 && sclOut == 1) tRise = cyc;
      if (prevScl == 1 && sclOut == 0) tFall = cyc;
      prevScl = sclOut;
      if (expQ.size() > 0) e = expQ.pop_front();
      else e = {curScl, curSda, 1'b1, 5'b0};
      check(curTag, {sclOut, sdaOut, ready, startDone, bitDone, stopDone},
            {e[7], e[6], e[5], e[4], e[3], e[2]});
      if (e[1]) check("R7 sample", rxBit, e[0]);
    end
  end

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    applyCfg(1, 9, 7, 2, 1, 3, 2, 4, 2, 1);
    repeat (3) @(negedge clk);
    check("R1 reset", {sclOut, sdaOut, ready, startDone, bitDone, stopDone}, 6'b111000);
    rstN = 1;
    repeat (4) @(negedge clk);
    // R10: bit on a free bus must leave everything unchanged
    curTag = "R10";
    reqBit = 1; bitValue = 0;
    @(negedge clk); reqBit = 0;
    repeat (4) @(negedge clk);
    doStop();                 // R9
    doStart(0);               // R3
    doBit(1, 0, 0);
    doBit(0, 1, 0);
    doBit(1, 1, 1);           // R12
    doStart(1);               // R4 + R11
    doBit(0, 0, 0);
    doStop();                 // R8
    // Zero counts, no divide, stretched low, deepest filter (R2, R5)
    applyCfg(0, 2, 0, 4, 3, 0, 0, 0, 0, 7);
    doStart(0);
    doBit(1, 1, 0);
    doBit(0, 0, 0);
    doStart(0);
    doStop();
    // Wider divider (R2)
    applyCfg(3, 6, 3, 1, 2, 2, 1, 3, 1, 0);
    curTag = "R2";
    doStart(0);
    doBit(0, 1, 0);
    doBit(1, 0, 0);
    doStop();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule